// File: doc/BRIEF.md
# Programmable-Duty Serial Clock Pacer

This block produces the serial clock for a two-wire bus controller from the system clock. The clock-control word holds two separately programmed counts, one for the low phase and one for the high phase, so software sets both the bit rate and the duty cycle. The block never drives the line high. It pulls the line low through an open-drain drive-low output and watches the real line level through a two-flop synchronizer. Because it watches the line, it can share the clock with other controllers and tolerate a target that holds the clock low.

After the low phase it releases the line. It does not start the high phase until the synchronized line reads high, so any stretching adds to the bit time without shortening the high phase. If another device pulls the line low during the high phase, the high phase ends and a new low phase begins at once. Two single-cycle strobes mark the first cycle of each low phase and the first cycle of each high phase. Byte-level sequencing logic uses them as shift points. Counts below the minimum phase lengths are raised to those minimums. The reset is asynchronous and active low, and the surrounding logic is expected to release it synchronously to the clock.

Top module: `scl_pacer`

## Requirements
- R1: With low count lo = cfg_word[7:0] (lo at least 4), `scl_drive_low` is 1 for exactly lo+1 consecutive clock cycles in each low phase. A low phase ended early by R7 is followed by a full low phase.
- R2: With high count hi = cfg_word[15:8] (hi at least 2), the high phase lasts hi+1 cycles. It is measured from the cycle in which `rise_stb` is 1 up to, but not including, the cycle in which the next `low_start_stb` is 1, provided nothing pulls the line low meanwhile.
- R3: A low count below 4 gives a 5-cycle low phase, and a high count below 2 gives a 3-cycle high phase.
- R4: `low_start_stb` is 1 only in the first cycle of a low phase, and `rise_stb` is 1 only in the first cycle of a high phase. Each lasts one cycle.
- R5: While `en` is 0, `scl_drive_low`, `low_start_stb` and `rise_stb` are all 0. When `en` goes to 1, sampled at a clock edge, the following cycle is the first cycle of a full-length low phase.
- R6: After the line is released, `rise_stb` appears in the third cycle after `scl_in` reads 1. An external low hold of S cycles after release therefore delays `rise_stb` by S cycles but leaves the high-phase length of R2 unchanged.
- R7: If `scl_in` goes to 0 during a high phase, `low_start_stb` appears in the third cycle after it does, and the high phase ends there.
- R8: When nothing else holds the line, consecutive `low_start_stb` pulses are L+3+H cycles apart. L and H are the phase lengths of R1 to R3, and 3 is the release-to-detect latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Run enable. When 0, the line is released and the phase counters are cleared |
| cfg_word | input | 16 | Clock control: [7:0] low count, [15:8] high count |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| low_start_stb | output | 1 | One-cycle pulse in the first cycle of a low phase |
| rise_stb | output | 1 | One-cycle pulse in the first cycle of a high phase |

## Verification
The assertions assume that `cfg_word` is held steady while the block runs. They also assume that the line level on `scl_in` follows the block's own drive, except where another device deliberately holds it low. The bench changes `cfg_word` only while `en` is 0. It models the line as low whenever either the block or a test-controlled external holder pulls it down. Every external hold starts and ends on the falling clock edge, so the synchronizer latency the requirements count is well defined.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= line_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign line_sync = chain_q[STAGES-1];
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int CNT_W    = 8,
  parameter int LO_FLOOR = 4,
  parameter int HI_FLOOR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lo_raw,
  input  logic [CNT_W-1:0] hi_raw,
  input  logic             sel_hi,
  input  logic             clr,
  input  logic             inc,
  output logic             cnt_zero,
  output logic             cnt_last
);
  localparam logic [CNT_W-1:0] LO_MIN = CNT_W'(LO_FLOOR);
  localparam logic [CNT_W-1:0] HI_MIN = CNT_W'(HI_FLOOR);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lo_eff, hi_eff, limit;

  always_comb begin
    lo_eff = (lo_raw < LO_MIN) ? LO_MIN : lo_raw;
    hi_eff = (hi_raw < HI_MIN) ? HI_MIN : hi_raw;
    limit  = sel_hi ? hi_eff : lo_eff;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == limit);

  // R1 / R2: a counting step advances by exactly one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3: a counting phase never runs past its clamped limit
  a_r3_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && $stable(lo_raw) && $stable(hi_raw) && $stable(sel_hi)) |-> (cnt_q < limit));
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LO_FLOOR    = 4,
  parameter int HI_FLOOR    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2*CNT_W-1:0] cfg_word,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             low_start_stb,
  output logic             rise_stb
);
  import scl_pacer_pkg::*;

  scl_phase_e st_q, st_d;
  logic       line_s;
  logic       cnt_clr, cnt_inc, cnt_zero, cnt_last;

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_raw (scl_in),
    .line_sync(line_s)
  );

  scl_phase_cnt #(
    .CNT_W   (CNT_W),
    .LO_FLOOR(LO_FLOOR),
    .HI_FLOOR(HI_FLOOR)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_raw  (cfg_word[CNT_W-1:0]),
    .hi_raw  (cfg_word[2*CNT_W-1:CNT_W]),
    .sel_hi  (st_q == PH_HIGH),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .cnt_zero(cnt_zero),
    .cnt_last(cnt_last)
  );

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (!en) begin
      st_d    = PH_IDLE;
      cnt_clr = 1'b1;
    end else begin
      case (st_q)
        PH_IDLE: begin
          st_d    = PH_LOW;
          cnt_clr = 1'b1;
        end
        PH_LOW: begin
          if (cnt_last) begin
            st_d    = PH_WAIT;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        PH_WAIT: begin
          cnt_clr = 1'b1;
          if (line_s) st_d = PH_HIGH;
        end
        PH_HIGH: begin
          if (!line_s || cnt_last) begin
            st_d    = PH_LOW;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        default: begin
          st_d    = PH_IDLE;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PH_IDLE;
    else        st_q <= st_d;
  end

  assign scl_drive_low = (st_q == PH_LOW);
  assign low_start_stb = (st_q == PH_LOW)  && cnt_zero;
  assign rise_stb      = (st_q == PH_HIGH) && cnt_zero;

  // R5: disabling releases the line and silences both strobes
  a_r5_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !low_start_stb && !rise_stb));

  // R6: a high phase only starts once the synchronized line reads high
  a_r6_rise_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $past(line_s));

  // R7: a line pulled low during the high phase starts a low phase
  a_r7_early_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_HIGH && !line_s && en) |=> low_start_stb);

  // R4: a low-phase strobe is never followed by another in the next cycle
  a_r4_single_low_stb: assert property (@(posedge clk) disable iff (!rst_n)
    low_start_stb |=> !low_start_stb);

  // R1: the last counted low cycle releases the line
  a_r1_low_release: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && cnt_last) |=> !scl_drive_low);
endmodule

// File: tb/test_scl_pacer.sv
module test_scl_pacer;
  logic        clk = 1'b0;
  logic        rst_n, en, ext_low;
  logic [15:0] cfg_word;
  logic        scl_in, scl_drive_low, low_start_stb, rise_stb;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  assign scl_in = !(scl_drive_low || ext_low);

  scl_pacer i_scl_pacer (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .cfg_word     (cfg_word),
    .scl_in       (scl_in),
    .scl_drive_low(scl_drive_low),
    .low_start_stb(low_start_stb),
    .rise_stb     (rise_stb)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge where low_start_stb is 1; ends at the next such edge.
  task automatic run_cycle(input int stretch, input int pull_at,
                           output int lo_len, output int wait_len, output int hi_len);
    lo_len = 0;
    while (scl_drive_low && lo_len < 1000) begin
      if (lo_len == 1) chk(int'(low_start_stb), 0, "R4 low strobe width");
      lo_len++;
      @(negedge clk);
    end
    wait_len = 0;
    while (!rise_stb && wait_len < 1000) begin
      ext_low = (wait_len < stretch);
      wait_len++;
      @(negedge clk);
    end
    ext_low = 1'b0;
    hi_len = 0;
    while (!low_start_stb && hi_len < 1000) begin
      if (hi_len == 1) chk(int'(rise_stb), 0, "R4 rise strobe width");
      if (pull_at > 0 && hi_len == pull_at) ext_low = 1'b1;
      hi_len++;
      @(negedge clk);
    end
    ext_low = 1'b0;
  endtask

  task automatic start_run(input logic [7:0] lo, input logic [7:0] hi);
    en = 1'b0;
    @(negedge clk);
    cfg_word = {hi, lo};
    en = 1'b1;
    @(negedge clk);
    chk(int'(low_start_stb), 1, "R5 low strobe after enable");
    chk(int'(scl_drive_low), 1, "R5 drive after enable");
  endtask

  task automatic t_phase(input logic [7:0] lo, input logic [7:0] hi,
                         input int exp_l, input int exp_h, input string tag);
    int l, w, h, l2, w2, h2;
    start_run(lo, hi);
    run_cycle(0, 0, l, w, h);
    run_cycle(0, 0, l2, w2, h2);
    chk(l, exp_l, {tag, " R1 low length"});
    chk(h, exp_h, {tag, " R2 high length"});
    chk(w, 3, {tag, " R6 release latency"});
    chk(l2 + w2 + h2, exp_l + exp_h + 3, {tag, " R8 period"});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b0; ext_low = 1'b0; cfg_word = 16'h0609;
    repeat (3) @(negedge clk);
    chk(int'(scl_drive_low), 0, "R5 reset drive");
    chk(int'(low_start_stb) + int'(rise_stb), 0, "R5 reset strobes");
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(scl_drive_low), 0, "R5 idle after reset");
  endtask

  task automatic t_clamp;
    t_phase(8'd0, 8'd0, 5, 3, "clamp zero R3");
    t_phase(8'd3, 8'd1, 5, 3, "clamp below R3");
    t_phase(8'd4, 8'd2, 5, 3, "floor exact R3");
    t_phase(8'd5, 8'd3, 6, 4, "above floor R3");
  endtask

  task automatic t_stretch;
    int l, w, h;
    start_run(8'd7, 8'd5);
    run_cycle(9, 0, l, w, h);
    chk(w, 12, "R6 stretched wait");
    chk(h, 6, "R6 high length after stretch");
    chk(l, 8, "R1 low length before stretch");
  endtask

  task automatic t_early;
    int l, w, h;
    start_run(8'd6, 8'd20);
    run_cycle(0, 2, l, w, h);
    chk(h, 5, "R7 early high end");
    run_cycle(0, 0, l, w, h);
    chk(l, 7, "R1 full low after early end");
    chk(h, 21, "R2 high length after early end");
  endtask

  task automatic t_enable;
    int quiet, l, w, h;
    en = 1'b0;
    @(negedge clk);
    quiet = 0;
    for (int i = 0; i < 8; i++) begin
      quiet += int'(scl_drive_low) + int'(low_start_stb) + int'(rise_stb);
      @(negedge clk);
    end
    chk(quiet, 0, "R5 disabled outputs");
    start_run(8'd10, 8'd4);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(int'(scl_drive_low), 0, "R5 release on disable");
    en = 1'b1;
    @(negedge clk);
    chk(int'(low_start_stb), 1, "R5 restart strobe");
    run_cycle(0, 0, l, w, h);
    chk(l, 11, "R5 full low after restart");
  endtask

  initial begin
    t_reset();
    t_phase(8'd9, 8'd6, 10, 7, "basic");
    t_phase(8'd20, 8'd3, 21, 4, "skewed");
    t_phase(8'd255, 8'd255, 256, 256, "maximum");
    t_clamp();
    t_stretch();
    t_early();
    t_enable();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule